// File: doc/BRIEF.md
# Butterfly Schedule Sequencer for a Forward-Backward Soft Decoder

This block drives the control side of one soft-input soft-output decoder that runs the forward-backward recursions over a subblock of N symbols. Once started it emits, every cycle, the symbol index of the forward recursion and of the backward recursion, a shared slot address for the state metric memory, read and write enables for the forward-metric bank (alpha) and the backward-metric bank (beta), and extrinsic-output enables for each direction. The two recursions begin together at the two ends of the subblock, one symbol per cycle each, so a whole pass takes N cycles. The arithmetic datapath and the memory itself live outside.

Three schedules are selected by `sched_mode`. In the plain butterfly schedule the first half only stores metrics and the second half emits extrinsics in both directions. In the replica schedule both directions emit extrinsics every cycle, pairing the live recursion with the opposite metric kept from the previous pass, so each bank is read and rewritten at the same slot every cycle. In the forward-only schedule only the forward side emits, and a single beta bank of depth floor(N/2) is read and rewritten each cycle; no alpha bank is used.

The slot address folds the subblock around its middle: both recursions touch the same slot in every cycle, so a metric stored at slot k is read back exactly when the opposite recursion reaches the mirrored symbol. States: IDLE (waiting), FIRST (first half, cycles k < floor(N/2)), SECOND (remaining cycles), DONE (one cycle). Transitions: IDLE or DONE to FIRST on an accepted start (to SECOND when N = 1), FIRST to SECOND after cycle floor(N/2)-1, SECOND to DONE after cycle N-1, DONE to IDLE without a start.

Top module: `bfly_sched_seq`

## Requirements
- R1: A start pulse with `sub_len` nonzero, sampled while not busy (IDLE or DONE), makes `busy` high from the next cycle for exactly N cycles; `sub_len` above MAX_N is treated as MAX_N, and `sub_len` = 0 is ignored with all outputs staying low.
- R2: In busy cycle k (k = 0 .. N-1) `fwd_addr` = k and `bwd_addr` = N-1-k; `fwd_start` and `bwd_start` are high only in cycle k = 0.
- R3: With H = floor(N/2), `sm_slot` is k when k < H and N-1-k otherwise; outside busy cycles all addresses are 0.
- R4: Mode 0 (butterfly; mode 3 behaves the same): for k < H, `alpha_wr` and `beta_wr` are high and both extrinsic enables are low; for k >= H, `fwd_ext_en` is high, `bwd_ext_en` is high when N-1-k < H, and `alpha_rd`, `beta_rd` are high except in the middle cycle.
- R5: For odd N the middle cycle k = H has all four memory enables low, and in modes 0 and 2 the middle symbol gets exactly one extrinsic enable (forward).
- R6: Mode 1 (replica): `fwd_ext_en` and `bwd_ext_en` are high in every busy cycle, and all four memory enables are high in every busy cycle except the middle one.
- R7: Mode 2 (forward only): `fwd_ext_en` is high in every busy cycle, `bwd_ext_en`, `alpha_wr` and `alpha_rd` are never high, and `beta_wr`, `beta_rd` are high in every non-middle cycle.
- R8: `done` is high for exactly one cycle, the cycle after the last busy cycle, with `busy` low; a start in that cycle begins a new pass immediately.
- R9: A start while busy is ignored: the length and mode of the running pass do not change and no second pass is queued.
- R10: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (sampled when not busy) |
| sub_len | input | $clog2(MAX_N+1) | Subblock length N |
| sched_mode | input | 2 | 0 butterfly, 1 replica, 2 forward only, 3 as 0 |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| fwd_start | output | 1 | Forward recursion start pulse |
| bwd_start | output | 1 | Backward recursion start pulse |
| fwd_addr | output | $clog2(MAX_N) | Forward recursion symbol index |
| bwd_addr | output | $clog2(MAX_N) | Backward recursion symbol index |
| sm_slot | output | $clog2(ceil(MAX_N/2)) | Shared state metric memory slot |
| alpha_wr | output | 1 | Write forward metric at slot |
| alpha_rd | output | 1 | Read forward metric at slot |
| beta_wr | output | 1 | Write backward metric at slot |
| beta_rd | output | 1 | Read backward metric at slot |
| fwd_ext_en | output | 1 | Extrinsic output alongside forward recursion |
| bwd_ext_en | output | 1 | Extrinsic output alongside backward recursion |

## Verification
The hardest cases to reach are the boundaries where a new start meets the sequencer in a non-idle state: a start in the single DONE cycle must launch a new pass with no gap, while a start a few cycles into a pass, carrying a different length and mode, must leave that pass untouched. The driver times both from the negative edge, relying on knowing exactly in which cycle DONE appears, and the scoreboard then compares every following cycle against the expected sequence. Odd lengths, a length of one and an over-range length push the middle-symbol and clamping paths.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    typedef enum logic [1:0] {
        MODE_BFLY    = 2'd0,
        MODE_REPLICA = 2'd1,
        MODE_FWD     = 2'd2,
        MODE_RSV     = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_DONE   = 2'd3
    } state_e;

    typedef struct packed {
        logic alpha_wr;
        logic alpha_rd;
        logic beta_wr;
        logic beta_rd;
        logic fwd_ext;
        logic bwd_ext;
    } en_t;
endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
    import bfly_pkg::*;
#(
    parameter int MAX_N = 64,
    localparam int AW = (MAX_N > 1) ? $clog2(MAX_N) : 1,
    localparam int LW = $clog2(MAX_N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  logic [1:0]    mode,
    output state_e        st,
    output logic [AW-1:0] step,
    output logic [LW-1:0] n_len,
    output logic [LW-1:0] h_len,
    output mode_e         mode_q,
    output logic          last
);
    localparam logic [LW-1:0] LEN_MAX = LW'(MAX_N);

    state_e        st_q, st_d;
    logic [AW-1:0] t_q, t_d;
    logic [LW-1:0] n_q, n_d, h_q, h_d;
    mode_e         m_q, m_d;
    logic [LW-1:0] len_eff;
    logic          accept;

    assign len_eff = (len > LEN_MAX) ? LEN_MAX : len;
    assign accept  = ((st_q == ST_IDLE) || (st_q == ST_DONE)) && start && (len != '0);
    assign last    = (st_q == ST_SECOND) && (LW'(t_q) == n_q - LW'(1));

    always_comb begin
        st_d = st_q;
        t_d  = t_q;
        n_d  = n_q;
        h_d  = h_q;
        m_d  = m_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    n_d  = len_eff;
                    h_d  = len_eff >> 1;
                    m_d  = mode_e'(mode);
                    t_d  = '0;
                    st_d = ((len_eff >> 1) == '0) ? ST_SECOND : ST_FIRST;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_FIRST: begin
                t_d = t_q + AW'(1);
                if (LW'(t_q) + LW'(1) == h_q) st_d = ST_SECOND;
            end
            ST_SECOND: begin
                if (last) st_d = ST_DONE;
                else      t_d  = t_q + AW'(1);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            t_q  <= '0;
            n_q  <= '0;
            h_q  <= '0;
            m_q  <= MODE_BFLY;
        end else begin
            st_q <= st_d;
            t_q  <= t_d;
            n_q  <= n_d;
            h_q  <= h_d;
            m_q  <= m_d;
        end
    end

    assign st     = st_q;
    assign step   = t_q;
    assign n_len  = n_q;
    assign h_len  = h_q;
    assign mode_q = m_q;

    // R9: configuration of a running pass stays fixed
    a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_FIRST) || (st_q == ST_SECOND)) && !last
        |=> $stable(n_q) && $stable(m_q));

    // R1: one symbol per cycle while running
    a_r1_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_FIRST) || (st_q == ST_SECOND)) && !last
        |=> t_q == $past(t_q) + AW'(1));

    // R8: completion state lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |=> (st_q != ST_DONE));

    // R1: a running pass never has zero length
    a_r1_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIRST || st_q == ST_SECOND) |-> (n_q != '0));
endmodule

// File: rtl/bfly_addr.sv
module bfly_addr #(
    parameter int MAX_N = 64,
    localparam int AW    = (MAX_N > 1) ? $clog2(MAX_N) : 1,
    localparam int LW    = $clog2(MAX_N + 1),
    localparam int DEPTH = (MAX_N + 1) / 2,
    localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0] step,
    input  logic [LW-1:0] n_len,
    input  logic [LW-1:0] h_len,
    output logic [AW-1:0] f_addr,
    output logic [AW-1:0] b_addr,
    output logic [SW-1:0] slot,
    output logic          first_half,
    output logic          middle,
    output logic          b_low
);
    logic [LW-1:0] t_w, b_w;

    always_comb begin
        t_w        = LW'(step);
        b_w        = n_len - LW'(1) - t_w;
        f_addr     = step;
        b_addr     = AW'(b_w);
        first_half = (t_w < h_len);
        middle     = n_len[0] && (t_w == h_len);
        b_low      = (b_w < h_len);
        slot       = first_half ? SW'(t_w) : SW'(b_w);
    end
endmodule

// File: rtl/bfly_enables.sv
module bfly_enables
    import bfly_pkg::*;
(
    input  logic  run,
    input  mode_e mode_q,
    input  logic  first_half,
    input  logic  middle,
    input  logic  b_low,
    output en_t   en
);
    always_comb begin
        en = '0;
        if (run) begin
            unique case (mode_q)
                MODE_REPLICA: begin
                    en.alpha_wr = !middle;
                    en.alpha_rd = !middle;
                    en.beta_wr  = !middle;
                    en.beta_rd  = !middle;
                    en.fwd_ext  = 1'b1;
                    en.bwd_ext  = 1'b1;
                end
                MODE_FWD: begin
                    en.beta_wr = !middle;
                    en.beta_rd = !middle;
                    en.fwd_ext = 1'b1;
                end
                default: begin
                    en.alpha_wr = first_half;
                    en.beta_wr  = first_half;
                    en.alpha_rd = !first_half && !middle;
                    en.beta_rd  = !first_half && !middle;
                    en.fwd_ext  = !first_half;
                    en.bwd_ext  = !first_half && b_low;
                end
            endcase
        end
    end
endmodule

// File: rtl/bfly_sched_seq.sv
module bfly_sched_seq
    import bfly_pkg::*;
#(
    parameter int MAX_N = 64,
    localparam int AW    = (MAX_N > 1) ? $clog2(MAX_N) : 1,
    localparam int LW    = $clog2(MAX_N + 1),
    localparam int DEPTH = (MAX_N + 1) / 2,
    localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] sub_len,
    input  logic [1:0]    sched_mode,
    output logic          busy,
    output logic          done,
    output logic          fwd_start,
    output logic          bwd_start,
    output logic [AW-1:0] fwd_addr,
    output logic [AW-1:0] bwd_addr,
    output logic [SW-1:0] sm_slot,
    output logic          alpha_wr,
    output logic          alpha_rd,
    output logic          beta_wr,
    output logic          beta_rd,
    output logic          fwd_ext_en,
    output logic          bwd_ext_en
);
    state_e        st;
    logic [AW-1:0] step, f_a, b_a;
    logic [LW-1:0] n_len, h_len;
    mode_e         mode_q;
    logic          last, first_half, middle, b_low, run;
    logic [SW-1:0] slot;
    en_t           en;

    bfly_ctrl #(.MAX_N(MAX_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .len(sub_len), .mode(sched_mode),
        .st(st), .step(step), .n_len(n_len), .h_len(h_len), .mode_q(mode_q), .last(last)
    );

    bfly_addr #(.MAX_N(MAX_N)) u_addr (
        .step(step), .n_len(n_len), .h_len(h_len),
        .f_addr(f_a), .b_addr(b_a), .slot(slot),
        .first_half(first_half), .middle(middle), .b_low(b_low)
    );

    assign run = (st == ST_FIRST) || (st == ST_SECOND);

    bfly_enables u_en (
        .run(run), .mode_q(mode_q), .first_half(first_half),
        .middle(middle), .b_low(b_low), .en(en)
    );

    always_comb begin
        busy       = run;
        done       = (st == ST_DONE);
        fwd_start  = run && (step == '0);
        bwd_start  = run && (step == '0);
        fwd_addr   = run ? f_a  : '0;
        bwd_addr   = run ? b_a  : '0;
        sm_slot    = run ? slot : '0;
        alpha_wr   = en.alpha_wr;
        alpha_rd   = en.alpha_rd;
        beta_wr    = en.beta_wr;
        beta_rd    = en.beta_rd;
        fwd_ext_en = en.fwd_ext;
        bwd_ext_en = en.bwd_ext;
    end

    // R10: nothing is enabled outside a pass
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(alpha_wr || alpha_rd || beta_wr || beta_rd || fwd_ext_en || bwd_ext_en));

    // R8: completion pulse never overlaps a pass
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: middle symbol touches no memory
    a_r5_middle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (fwd_addr == bwd_addr) |-> !(alpha_wr || alpha_rd || beta_wr || beta_rd));

    // R2: start pulses coincide with the first symbol
    a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_start |-> (fwd_addr == '0) && bwd_start);

    // R7: forward-only schedule never uses the alpha bank or backward extrinsics
    a_r7_fwd_only: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (mode_q == MODE_FWD) |-> !(alpha_wr || alpha_rd || bwd_ext_en));

    // R1: the recursions move toward each other
    a_r1_converge: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$past(done) && (fwd_addr != '0)
        |-> bwd_addr == $past(bwd_addr) - AW'(1));
endmodule

// File: tb/test_bfly_sched_seq.sv
module test_bfly_sched_seq;
    localparam int MAX_N = 64;
    localparam int AW    = $clog2(MAX_N);
    localparam int LW    = $clog2(MAX_N + 1);
    localparam int SW    = $clog2((MAX_N + 1) / 2);
    localparam int VW    = 4 + 2 * AW + SW + 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] sub_len = '0;
    logic [1:0]    sched_mode = 2'd0;
    logic          busy, done, fwd_start, bwd_start;
    logic [AW-1:0] fwd_addr, bwd_addr;
    logic [SW-1:0] sm_slot;
    logic          alpha_wr, alpha_rd, beta_wr, beta_rd, fwd_ext_en, bwd_ext_en;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    logic [VW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    bfly_sched_seq #(.MAX_N(MAX_N)) i_bfly_sched_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_len(sub_len), .sched_mode(sched_mode),
        .busy(busy), .done(done), .fwd_start(fwd_start), .bwd_start(bwd_start),
        .fwd_addr(fwd_addr), .bwd_addr(bwd_addr), .sm_slot(sm_slot),
        .alpha_wr(alpha_wr), .alpha_rd(alpha_rd), .beta_wr(beta_wr), .beta_rd(beta_rd),
        .fwd_ext_en(fwd_ext_en), .bwd_ext_en(bwd_ext_en)
    );

    function automatic logic [VW-1:0] actual_vec();
        return {busy, done, fwd_start, bwd_start, fwd_addr, bwd_addr, sm_slot,
                alpha_wr, alpha_rd, beta_wr, beta_rd, fwd_ext_en, bwd_ext_en};
    endfunction

    // Expected outputs for busy cycle k of a pass of length n in mode m
    function automatic logic [VW-1:0] exp_vec(int n, int m, int k);
        int  h = n / 2;
        bit  mid = (n % 2 == 1) && (k == h);
        bit  first = (k < h);
        int  slot = first ? k : n - 1 - k;
        bit  aw = 0, ar = 0, bw = 0, br = 0, fe = 0, be = 0;
        int  bm = (m == 3) ? 0 : m;
        if (bm == 0) begin
            aw = first; bw = first;
            ar = !first && !mid; br = !first && !mid;
            fe = !first; be = !first && ((n - 1 - k) < h);
        end else if (bm == 1) begin
            aw = !mid; ar = !mid; bw = !mid; br = !mid; fe = 1; be = 1;
        end else begin
            bw = !mid; br = !mid; fe = 1;
        end
        return {1'b1, 1'b0, (k == 0), (k == 0), AW'(k), AW'(n - 1 - k), SW'(slot),
                aw, ar, bw, br, fe, be};
    endfunction

    function automatic string tag_for(int n, int m, int k);
        if (k == 0) return "R2";
        if ((n % 2 == 1) && (k == n / 2)) return "R5";
        if (m == 1) return "R6";
        if (m == 2) return "R7";
        return "R4";
    endfunction

    // Monitor: compares every cycle against the scoreboard, idle when empty
    always begin
        @(posedge clk);
        #1;
        if (mon_on) begin
            logic [VW-1:0] e;
            string t;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = '0;
                t = "R1/R10 idle";
            end
            checks++;
            if (actual_vec() !== e) begin
                errors++;
                $display("FAIL %s (R3 addr) actual=%h expected=%h at %0t", t, actual_vec(), e, $time);
            end
        end
    end

    // Driver: pushes the expected pass, pulses start; returns at the DONE cycle
    task automatic run_pass(int len_req, int m, bit inject);
        int n = (len_req > MAX_N) ? MAX_N : len_req;
        int remaining;
        if (n > 0) begin
            for (int k = 0; k < n; k++) begin
                exp_q.push_back(exp_vec(n, m, k));
                tag_q.push_back(tag_for(n, m, k));
            end
            exp_q.push_back({2'b01, {(VW - 2){1'b0}}});
            tag_q.push_back("R8");
        end
        sub_len    = LW'(len_req);
        sched_mode = 2'(m);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) return;
        remaining = n;
        if (inject && n >= 5) begin
            // R9: start with another length and mode while busy
            @(negedge clk);
            sub_len = LW'(3); sched_mode = 2'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0; sub_len = LW'(7); sched_mode = 2'd2;
            @(negedge clk);
            remaining = n - 3;
        end
        repeat (remaining) @(negedge clk);
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (actual_vec() !== '0) begin
            errors++;
            $display("FAIL R10 reset actual=%h expected=%h", actual_vec(), {VW{1'b0}});
        end
        mon_on = 1'b1;
        idle(1);
        run_pass(8, 0, 0);    // R4 even butterfly
        idle(2);
        run_pass(7, 0, 0);    // R4 R5 odd butterfly
        run_pass(6, 1, 0);    // R8 back-to-back, R6 replica
        idle(1);
        run_pass(5, 1, 0);    // R6 R5 odd replica
        idle(1);
        run_pass(9, 2, 0);    // R7 R5 forward only odd
        idle(1);
        run_pass(10, 2, 1);   // R7 with R9 injected start
        idle(1);
        run_pass(1, 0, 0);    // R5 single symbol
        idle(1);
        run_pass(0, 1, 0);    // R1 zero length ignored
        idle(3);
        run_pass(12, 3, 1);   // R4 reserved mode as butterfly, R9
        idle(1);
        run_pass(100, 2, 0);  // R1 clamp to MAX_N
        run_pass(2, 1, 0);    // R8 restart from DONE
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule